// File: doc/BRIEF.md
# Timer and interrupt control register

This block is the eight-bit control and status register that sits between an 8051-family core and its two timers and two external interrupt pins. Software sets the run enables of the timers and chooses, per pin, whether the external interrupt reacts to a falling edge or to a low level. Hardware raises the timer overflow flags and the external interrupt flags, and the core's interrupt-acknowledge strobes clear them again when it vectors to the matching service routine. The flags double as the interrupt request lines handed to the priority logic.

The register is reachable by a byte write at its own address and by single-bit writes at the eight bit addresses that start there. When timer 0 is placed in its split mode (mode 3), the upper half of timer 0 takes over timer 1's run bit and overflow flag. Timer 1 then runs unconditionally and cannot raise its flag.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset the register reads 00H, every interrupt request is low, and all run enables are low. The synchronizer stages reset to the idle-high pin level.
- R2: A byte write with address 88H loads the whole register, bit 7 down to bit 0 being: timer-1 flag, timer-1 run, timer-0 flag, timer-0 run, ext-1 flag, ext-1 type, ext-0 flag, ext-0 type. A byte write to any other address changes nothing.
- R3: A bit write with bit address 88H+n (n = 0..7) writes register bit n only. Other bit addresses change nothing. If a byte write and a bit write hit in the same cycle, the byte write wins.
- R4: An overflow pulse from timer 0 sets the timer-0 flag. Outside mode 3, an overflow pulse from timer 1 sets the timer-1 flag. A hardware set wins over a software clear and over an acknowledge in the same cycle.
- R5: An acknowledge strobe for timer 0 or timer 1 clears that timer's flag on the next clock edge, and wins over a software write in the same cycle.
- R6: The timer-0 run output equals the timer-0 run bit. Outside mode 3, the upper-half run output equals the timer-0 run bit and the timer-1 run output equals the timer-1 run bit.
- R7: While the mode-3 input is high, the timer-1 flag is set by the upper-half overflow and not by the timer-1 overflow. In this mode the upper-half run output equals the timer-1 run bit, and the timer-1 run output is 1.
- R8: With a type bit of 1 (edge mode), a high-to-low transition of the pin sets the ext flag. The pin passes through two synchronizer flops, so a pin that falls before clock edge k shows the flag after edge k+2. The flag stays set after the pin returns high.
- R9: In edge mode the ext flag is cleared by its acknowledge strobe or by a software write of 0. A detected edge in the same cycle wins.
- R10: With a type bit of 0 (level mode), the ext flag equals the inverted synchronized pin, with the same two-edge latency as R8. Software writes and acknowledges to that flag have no effect.
- R11: The request outputs equal the flags: irq_t0 is bit 5, irq_t1 is bit 7, irq_ext[0] is bit 1 and irq_ext[1] is bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_addr | input | 8 | Byte write address |
| sfr_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Bit write strobe |
| bit_addr | input | 8 | Bit write address |
| bit_wdata | input | 1 | Bit write data |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t0_hi_ovf | input | 1 | Timer 0 upper-half overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| t0_mode3 | input | 1 | Timer 0 is in split mode 3 |
| ext_irq_n | input | 2 | External interrupt pins, active low |
| ack_t0 | input | 1 | Core vectored to timer 0 interrupt |
| ack_t1 | input | 1 | Core vectored to timer 1 interrupt |
| ack_ext | input | 2 | Core vectored to external interrupt 0/1 |
| reg_q | output | 8 | Register value |
| t0_run | output | 1 | Timer 0 (lower half) run enable |
| t0_hi_run | output | 1 | Timer 0 upper-half run enable |
| t1_run | output | 1 | Timer 1 run enable |
| irq_t0 | output | 1 | Timer 0 interrupt request |
| irq_t1 | output | 1 | Timer 1 interrupt request |
| irq_ext | output | 2 | External interrupt requests |

## Verification
The hardest situations to reach are the collisions: an edge detected in the same cycle as an acknowledge or a software clear, and a mode-3 switch in the cycle when a timer-1 overflow and an upper-half overflow arrive together. Directed sequences first walk each path with known cycle timing, including the exact edge on which a synchronized falling pin sets its flag. A long stretch of random stimulus then pulses overflows, acknowledges, writes and pin toggles independently, so these collisions occur many times. A behavioural model is compared with every output on every clock.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned BIDX_W = $clog2(REG_W);

  // bit positions, fixed because software decodes them
  localparam int unsigned P_IT0 = 0;
  localparam int unsigned P_IE0 = 1;
  localparam int unsigned P_IT1 = 2;
  localparam int unsigned P_IE1 = 3;
  localparam int unsigned P_TR0 = 4;
  localparam int unsigned P_TF0 = 5;
  localparam int unsigned P_TR1 = 6;
  localparam int unsigned P_TF1 = 7;

  // per-bit software write enables; the byte write takes precedence
  function automatic logic [REG_W-1:0] f_sw_mask(input logic byte_hit,
                                                 input logic bit_hit,
                                                 input logic [BIDX_W-1:0] idx);
    logic [REG_W-1:0] m;
    m = '0;
    if (byte_hit) m = '1;
    else if (bit_hit) m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] f_sw_data(input logic byte_hit,
                                                 input logic [REG_W-1:0] bdata,
                                                 input logic bval);
    return byte_hit ? bdata : {REG_W{bval}};
  endfunction
endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic synced,
  output logic fell
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= pin_n;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign synced = chain[STAGES-1];
  assign fell   = prev & ~synced;
endmodule

// File: rtl/tic_flag.sv
module tic_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_we,
  input  logic sw_d,
  input  logic hw_set,
  input  logic hw_clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      q <= 1'b0;
    else if (hw_set) q <= 1'b1;
    else if (hw_clr) q <= 1'b0;
    else if (sw_we)  q <= sw_d;

  // R4: a hardware set is never lost
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q);
  // R5: an acknowledge without a set always clears
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr && !hw_set) |=> !q);
endmodule

// File: rtl/tic_ext_irq.sv
module tic_ext_irq #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic sw_we,
  input  logic sw_d,
  input  logic ack,
  output logic flag
);
  logic synced;
  logic fell;

  tic_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (pin_n),
    .synced (synced),
    .fell   (fell)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          flag <= 1'b0;
    else if (!edge_mode) flag <= ~synced;
    else if (fell)       flag <= 1'b1;
    else if (ack)        flag <= 1'b0;
    else if (sw_we)      flag <= sw_d;

  // R10: level mode tracks the pin, ignoring writes and acknowledges
  a_r10_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> (flag == ~$past(synced)));
  // R8: a detected edge in edge mode always lands
  a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fell) |=> flag);
  // R9: acknowledge without an edge clears in edge mode
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack && !fell) |=> !flag);
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h88,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_EXT       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  input  logic              bit_wr,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wdata,
  input  logic              t0_ovf,
  input  logic              t0_hi_ovf,
  input  logic              t1_ovf,
  input  logic              t0_mode3,
  input  logic [N_EXT-1:0]  ext_irq_n,
  input  logic              ack_t0,
  input  logic              ack_t1,
  input  logic [N_EXT-1:0]  ack_ext,
  output logic [7:0]        reg_q,
  output logic              t0_run,
  output logic              t0_hi_run,
  output logic              t1_run,
  output logic              irq_t0,
  output logic              irq_t1,
  output logic [N_EXT-1:0]  irq_ext
);
  import tic_pkg::*;

  localparam int unsigned HI_W = ADDR_W - BIDX_W;

  logic             byte_hit, bit_hit;
  logic [REG_W-1:0] sw_we, sw_d;
  logic             tr0_q, tr1_q, tf0_q, tf1_q;
  logic [N_EXT-1:0] it_q, ie_q;
  logic             tf1_set;

  assign byte_hit = sfr_wr && (sfr_addr == REG_ADDR);
  assign bit_hit  = bit_wr && (bit_addr[ADDR_W-1:BIDX_W] == REG_ADDR[ADDR_W-1:BIDX_W]);
  assign sw_we    = f_sw_mask(byte_hit, bit_hit, bit_addr[BIDX_W-1:0]);
  assign sw_d     = f_sw_data(byte_hit, sfr_wdata, bit_wdata);

  // software-only control bits
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tr0_q <= 1'b0;
      tr1_q <= 1'b0;
    end else begin
      if (sw_we[P_TR0]) tr0_q <= sw_d[P_TR0];
      if (sw_we[P_TR1]) tr1_q <= sw_d[P_TR1];
    end

  // timer-1 flag source is steered in split mode
  assign tf1_set = t0_mode3 ? t0_hi_ovf : t1_ovf;

  tic_flag u_tf0 (
    .clk (clk), .rst_n (rst_n),
    .sw_we (sw_we[P_TF0]), .sw_d (sw_d[P_TF0]),
    .hw_set (t0_ovf), .hw_clr (ack_t0), .q (tf0_q)
  );

  tic_flag u_tf1 (
    .clk (clk), .rst_n (rst_n),
    .sw_we (sw_we[P_TF1]), .sw_d (sw_d[P_TF1]),
    .hw_set (tf1_set), .hw_clr (ack_t1), .q (tf1_q)
  );

  generate
    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
      localparam int unsigned PT = P_IT0 + 2 * g;
      localparam int unsigned PE = P_IE0 + 2 * g;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        it_q[g] <= 1'b0;
        else if (sw_we[PT]) it_q[g] <= sw_d[PT];

      tic_ext_irq #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (ext_irq_n[g]),
        .edge_mode (it_q[g]),
        .sw_we     (sw_we[PE]),
        .sw_d      (sw_d[PE]),
        .ack       (ack_ext[g]),
        .flag      (ie_q[g])
      );
    end
  endgenerate

  assign reg_q     = {tf1_q, tr1_q, tf0_q, tr0_q, ie_q[1], it_q[1], ie_q[0], it_q[0]};
  assign t0_run    = tr0_q;
  assign t0_hi_run = t0_mode3 ? tr1_q : tr0_q;
  assign t1_run    = t0_mode3 ? 1'b1 : tr1_q;
  assign irq_t0    = tf0_q;
  assign irq_t1    = tf1_q;
  assign irq_ext   = ie_q;

  // R7: in split mode a timer-1 overflow alone cannot raise the timer-1 flag
  a_r7_t1_ovf_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_mode3 && !t0_hi_ovf && !tf1_q && !sw_we[P_TF1]) |=> !reg_q[P_TF1]);
  // R3: a bit write leaves the other seven bits alone when nothing else acts
  a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_hit && !byte_hit && bit_addr[BIDX_W-1:0] == 3'(P_TR0))
      |=> (reg_q[P_TR1] == $past(reg_q[P_TR1]) && reg_q[P_IT0] == $past(reg_q[P_IT0])));
endmodule

// File: tb/tmr_irq_ctl_bench.sv
`timescale 1ns/1ps
module tmr_irq_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_wr = 0, bit_wr = 0, bit_wdata = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, bit_addr = 0;
  logic       t0_ovf = 0, t0_hi_ovf = 0, t1_ovf = 0, t0_mode3 = 0;
  logic [1:0] ext_irq_n = 2'b11, ack_ext = 0;
  logic       ack_t0 = 0, ack_t1 = 0;
  logic [7:0] reg_q;
  logic       t0_run, t0_hi_run, t1_run, irq_t0, irq_t1;
  logic [1:0] irq_ext;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_irq_ctl u_tmr_irq_ctl (
    .clk (clk), .rst_n (rst_n),
    .sfr_wr (sfr_wr), .sfr_addr (sfr_addr), .sfr_wdata (sfr_wdata),
    .bit_wr (bit_wr), .bit_addr (bit_addr), .bit_wdata (bit_wdata),
    .t0_ovf (t0_ovf), .t0_hi_ovf (t0_hi_ovf), .t1_ovf (t1_ovf), .t0_mode3 (t0_mode3),
    .ext_irq_n (ext_irq_n), .ack_t0 (ack_t0), .ack_t1 (ack_t1), .ack_ext (ack_ext),
    .reg_q (reg_q), .t0_run (t0_run), .t0_hi_run (t0_hi_run), .t1_run (t1_run),
    .irq_t0 (irq_t0), .irq_t1 (irq_t1), .irq_ext (irq_ext)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_reg;
  logic [1:0] ms0, ms1, mpv;
  logic [7:0] nx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 8'h00; ms0 = 2'b11; ms1 = 2'b11; mpv = 2'b11;
    end else begin
      nx = m_reg;
      if (sfr_wr && sfr_addr == 8'h88) nx = sfr_wdata;
      else if (bit_wr && bit_addr >= 8'h88 && bit_addr <= 8'h8F) nx[bit_addr[2:0]] = bit_wdata;
      if (ack_t0) nx[5] = 1'b0;
      if (ack_t1) nx[7] = 1'b0;
      for (int g = 0; g < 2; g++)
        if (ack_ext[g] && m_reg[2*g]) nx[2*g+1] = 1'b0;
      if (t0_ovf) nx[5] = 1'b1;
      if (t0_mode3 ? t0_hi_ovf : t1_ovf) nx[7] = 1'b1;
      for (int g = 0; g < 2; g++) begin
        if (m_reg[2*g]) begin
          if (mpv[g] && !ms1[g]) nx[2*g+1] = 1'b1;
        end else nx[2*g+1] = ~ms1[g];
      end
      mpv = ms1; ms1 = ms0; ms0 = ext_irq_n; m_reg = nx;
    end
  end

  function automatic string bit_tag(input int b);
    case (b)
      7, 5:    return "R4/R5/R7 timer flag";
      6, 4:    return "R2/R3 run bit";
      3, 1:    return "R8/R9/R10 ext flag";
      default: return "R2/R3 type bit";
    endcase
  endfunction

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_q !== m_reg) begin
        for (int b = 7; b >= 0; b--)
          if (reg_q[b] !== m_reg[b]) begin
            chk(0, bit_tag(b), reg_q, m_reg);
            break;
          end
      end else chk(1, "reg", 0, 0);
      chk({t0_run, t0_hi_run, t1_run} ===
          {m_reg[4], t0_mode3 ? m_reg[6] : m_reg[4], t0_mode3 ? 1'b1 : m_reg[6]},
          "R6/R7 run outputs", {t0_run, t0_hi_run, t1_run},
          {m_reg[4], t0_mode3 ? m_reg[6] : m_reg[4], t0_mode3 ? 1'b1 : m_reg[6]});
      chk({irq_t1, irq_t0, irq_ext} === {m_reg[7], m_reg[5], m_reg[3], m_reg[1]},
          "R11 requests", {irq_t1, irq_t0, irq_ext}, {m_reg[7], m_reg[5], m_reg[3], m_reg[1]});
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic idle;
    sfr_wr = 0; bit_wr = 0; t0_ovf = 0; t0_hi_ovf = 0; t1_ovf = 0;
    ack_t0 = 0; ack_t1 = 0; ack_ext = 0;
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    sfr_wr = 1; sfr_addr = a; sfr_wdata = d; tick; idle;
  endtask

  task automatic bitw(input logic [7:0] a, input logic v);
    bit_wr = 1; bit_addr = a; bit_wdata = v; tick; idle;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick; tick;
    rst_n = 1; #1;
    // R1: reset state
    chk(reg_q == 8'h00 && {irq_t1, irq_t0, irq_ext} == 0, "R1 reset reg", reg_q, 0);
    chk({t0_run, t0_hi_run, t1_run} == 0, "R1 reset runs", {t0_run, t0_hi_run, t1_run}, 0);

    // R2: byte write at 88H, other address ignored
    bwrite(8'h88, 8'h50);
    chk(reg_q == 8'h50, "R2 byte write", reg_q, 8'h50);
    bwrite(8'h89, 8'hFF);
    chk(reg_q == 8'h50, "R2 other address", reg_q, 8'h50);

    // R6: runs follow TR bits outside split mode
    chk(t0_run && t0_hi_run && t1_run, "R6 runs", {t0_run, t0_hi_run, t1_run}, 3'b111);

    // R3: bit write of bit 4 (timer-0 run) to 0, bit addr 90H ignored
    bitw(8'h8C, 1'b0);
    chk(reg_q == 8'h40, "R3 bit write", reg_q, 8'h40);
    bitw(8'h90, 1'b1);
    chk(reg_q == 8'h40, "R3 foreign bit address", reg_q, 8'h40);
    // R3: byte write beats bit write in the same cycle
    sfr_wr = 1; sfr_addr = 8'h88; sfr_wdata = 8'h00; bit_wr = 1; bit_addr = 8'h8E; bit_wdata = 1;
    tick; idle;
    chk(reg_q == 8'h00, "R3 byte beats bit", reg_q, 0);

    // R4: overflow sets; set beats software clear
    t0_ovf = 1; tick; idle;
    chk(irq_t0 == 1, "R4 t0 overflow", irq_t0, 1);
    t1_ovf = 1; bit_wr = 1; bit_addr = 8'h8F; bit_wdata = 0; tick; idle;
    chk(reg_q[7] == 1, "R4 set beats clear", reg_q[7], 1);

    // R5: acknowledge clears both timer flags
    ack_t0 = 1; ack_t1 = 1; tick; idle;
    chk(reg_q[7] == 0 && reg_q[5] == 0, "R5 ack clears", reg_q, 0);

    // R7: split mode steering
    t0_mode3 = 1; bitw(8'h8E, 1'b1);
    t1_ovf = 1; tick; idle;
    chk(reg_q[7] == 0, "R7 t1 overflow masked", reg_q[7], 0);
    t0_hi_ovf = 1; tick; idle;
    chk(reg_q[7] == 1, "R7 upper half sets flag", reg_q[7], 1);
    bitw(8'h8E, 1'b0);
    chk(t0_hi_run == 0 && t1_run == 1, "R7 run steering", {t0_hi_run, t1_run}, 2'b01);
    t0_mode3 = 0;
    bwrite(8'h88, 8'h05); // both pins edge mode

    // R8: synchronized falling edge sets flag after edge k+2
    ext_irq_n[0] = 0; tick; tick;
    chk(reg_q[1] == 0, "R8 not yet", reg_q[1], 0);
    tick;
    chk(reg_q[1] == 1, "R8 edge sets", reg_q[1], 1);
    ext_irq_n[0] = 1; tick; tick; tick;
    chk(reg_q[1] == 1, "R8 stays latched", reg_q[1], 1);

    // R9: acknowledge clears, software clear also
    ack_ext[0] = 1; tick; idle;
    chk(reg_q[1] == 0, "R9 ack clears", reg_q[1], 0);
    bitw(8'h89, 1'b1);
    bitw(8'h89, 1'b0);
    chk(reg_q[1] == 0, "R9 software clear", reg_q[1], 0);

    // R10: level mode on pin 1
    bitw(8'h8A, 1'b0);
    ext_irq_n[1] = 0; tick; tick; tick;
    chk(reg_q[3] == 1, "R10 level follows", reg_q[3], 1);
    bitw(8'h8B, 1'b0);
    chk(reg_q[3] == 1, "R10 write ignored", reg_q[3], 1);
    ack_ext[1] = 1; tick; idle;
    chk(reg_q[3] == 1, "R10 ack ignored", reg_q[3], 1);
    ext_irq_n[1] = 1; tick; tick; tick;
    chk(reg_q[3] == 0, "R10 level releases", reg_q[3], 0);
    chk(irq_ext[1] == reg_q[3], "R11 ext request", irq_ext[1], reg_q[3]);

    // random phase, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      sfr_wr    = ($urandom % 16) == 0;
      sfr_addr  = ($urandom % 2) ? 8'h88 : 8'h87;
      sfr_wdata = 8'($urandom);
      bit_wr    = ($urandom % 6) == 0;
      bit_addr  = 8'h86 + 8'($urandom % 12);
      bit_wdata = 1'($urandom);
      t0_ovf    = ($urandom % 7) == 0;
      t0_hi_ovf = ($urandom % 7) == 0;
      t1_ovf    = ($urandom % 7) == 0;
      if (($urandom % 40) == 0) t0_mode3 = ~t0_mode3;
      if (($urandom % 5) == 0) ext_irq_n = 2'($urandom);
      ack_t0    = ($urandom % 8) == 0;
      ack_t1    = ($urandom % 8) == 0;
      ack_ext   = 2'($urandom) & 2'($urandom);
      tick;
    end
    idle; tick; tick;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule